// File: doc/BRIEF.md
# Priority Input Clock Selector

This block decides which of two reference clock inputs feeds a downstream PLL. It does not touch the clocks. It takes per-input alarm flags and per-input priority settings, works out which inputs are usable, and names one input as the selected source. A mode code chooses between manual and automatic selection. Manual selection takes its value from a pin or from a register bit. Automatic selection is ranked by priority and can be revertive or non-revertive.

The block produces three outputs:
- the index of the selected input;
- a flag that tells a mode controller whether a usable reference exists, so that it can fall back to holdover when none does;
- a single-cycle pulse on every change of the selection.

All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge.

Top module: `ref_sel_top`

## Requirements
- R1: While rst_ni is low, sel_o is 0, any_valid_o is 0 and switch_o is 0.
- R2: With mode_i = 2'b00 (manual), the source of the selection is chosen by sel_by_reg_i. A value of 0 takes sel_pin_i and a value of 1 takes sel_reg_i. A select value of 0 picks input 0 and a value of 1 picks input 1. sel_o shows the chosen input one cycle later.
- R3: mode_i = 2'b11 behaves exactly as manual mode.
- R4: In the automatic modes (mode_i = 2'b01 or 2'b10), sel_pin_i, sel_reg_i and sel_by_reg_i have no effect on sel_o.
- R5: An input is valid when it has neither an unmasked LOS alarm nor an unmasked OOF alarm. A mask bit of 1 hides that alarm from the decision. A mask bit of 0 lets it count. Bit k of each alarm and mask vector belongs to input k.
- R6: Input k has its priority in prio_i[3k+2:3k]. An input is eligible when it is valid and its priority is nonzero. Priority 0 means the input is never chosen automatically. A smaller nonzero value ranks higher. When two inputs share a priority, input 0 wins.
- R7: With mode_i = 2'b10 (revertive), sel_o takes the best-ranked eligible input after every cycle in which one exists. This includes returning to a higher-ranked input once it recovers.
- R8: With mode_i = 2'b01 (non-revertive), the current input stays selected while it is eligible. When it is not eligible, the best-ranked eligible input is taken.
- R9: In an automatic mode with no eligible input, sel_o holds its value and any_valid_o is 0. Otherwise any_valid_o is 1. In manual mode, any_valid_o equals the validity of the manually chosen input.
- R10: switch_o is 1 for exactly the cycles in which sel_o differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Switch mode: 00 manual, 01 auto non-revertive, 10 auto revertive, 11 as manual |
| sel_by_reg_i | input | 1 | Manual source: 0 pin, 1 register |
| sel_pin_i | input | 1 | Manual select from pin |
| sel_reg_i | input | 1 | Manual select from register |
| prio_i | input | 6 | Per-input 3-bit priorities, input k at bits 3k+2:3k |
| los_i | input | 2 | Per-input loss-of-signal alarm |
| los_mask_i | input | 2 | Per-input LOS mask, 1 hides the alarm |
| oof_i | input | 2 | Per-input out-of-frequency alarm |
| oof_mask_i | input | 2 | Per-input OOF mask, 1 hides the alarm |
| sel_o | output | 1 | Selected input index |
| any_valid_o | output | 1 | A usable reference exists |
| switch_o | output | 1 | One-cycle pulse on selection change |

## Verification
The hardest case to reach is a non-revertive hold in which a higher-ranked input becomes eligible while the current one stays healthy. Reaching it needs a failure, a switch away, and then a recovery of the original input, all under the same mode. The directed sequences build exactly that history. Random stimulus keeps alarms rare, so selections persist over many cycles instead of chattering. A bench model tracks the selected index and predicts every cycle's outputs from it.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  typedef enum logic [1:0] {
    SW_MANUAL      = 2'b00,
    SW_AUTO_HOLD   = 2'b01,
    SW_AUTO_REVERT = 2'b10,
    SW_RESERVED    = 2'b11
  } sw_mode_e;
endpackage

// File: rtl/ref_sel_qual.sv
module ref_sel_qual #(
  parameter int N_IN   = 2,
  parameter int PRIO_W = 3
) (
  input  logic [N_IN-1:0]        los_i,
  input  logic [N_IN-1:0]        los_mask_i,
  input  logic [N_IN-1:0]        oof_i,
  input  logic [N_IN-1:0]        oof_mask_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  output logic [N_IN-1:0]        valid_o,
  output logic [N_IN-1:0]        elig_o
);
  for (genvar k = 0; k < N_IN; k++) begin : g_in
    logic alarm;
    assign alarm      = (los_i[k] & ~los_mask_i[k]) | (oof_i[k] & ~oof_mask_i[k]);
    assign valid_o[k] = ~alarm;
    assign elig_o[k]  = ~alarm & (prio_i[k*PRIO_W +: PRIO_W] != '0);
  end
endmodule

// File: rtl/ref_sel_rank.sv
module ref_sel_rank #(
  parameter int N_IN   = 2,
  parameter int PRIO_W = 3,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0]        elig_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  output logic [SEL_W-1:0]       best_o,
  output logic                   found_o
);
  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare: ties go to the lower index
  always_comb begin
    best_o  = '0;
    found_o = 1'b0;
    best_p  = '0;
    for (int k = 0; k < N_IN; k++) begin
      if (elig_i[k] && (!found_o || prio_i[k*PRIO_W +: PRIO_W] < best_p)) begin
        best_o  = SEL_W'(k);
        best_p  = prio_i[k*PRIO_W +: PRIO_W];
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ref_sel_top.sv
module ref_sel_top
  import ref_sel_pkg::*;
#(
  parameter int N_IN   = 2,
  parameter int PRIO_W = 3,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             mode_i,
  input  logic                   sel_by_reg_i,
  input  logic [SEL_W-1:0]       sel_pin_i,
  input  logic [SEL_W-1:0]       sel_reg_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  input  logic [N_IN-1:0]        los_i,
  input  logic [N_IN-1:0]        los_mask_i,
  input  logic [N_IN-1:0]        oof_i,
  input  logic [N_IN-1:0]        oof_mask_i,
  output logic [SEL_W-1:0]       sel_o,
  output logic                   any_valid_o,
  output logic                   switch_o
);
  logic [N_IN-1:0]  valid, elig;
  logic [SEL_W-1:0] best_idx, man_idx, sel_q, sel_d;
  logic             found, av_d;
  sw_mode_e         mode;

  assign mode = sw_mode_e'(mode_i);

  ref_sel_qual #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_qual (
    .los_i      (los_i),
    .los_mask_i (los_mask_i),
    .oof_i      (oof_i),
    .oof_mask_i (oof_mask_i),
    .prio_i     (prio_i),
    .valid_o    (valid),
    .elig_o     (elig)
  );

  ref_sel_rank #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_rank (
    .elig_i  (elig),
    .prio_i  (prio_i),
    .best_o  (best_idx),
    .found_o (found)
  );

  assign man_idx = sel_by_reg_i ? sel_reg_i : sel_pin_i;

  always_comb begin
    sel_d = sel_q;
    av_d  = 1'b0;
    unique case (mode)
      SW_AUTO_REVERT: begin
        if (found) sel_d = best_idx;
        av_d = found;
      end
      SW_AUTO_HOLD: begin
        if (!elig[sel_q] && found) sel_d = best_idx;
        av_d = found;
      end
      default: begin  // manual and reserved
        sel_d = man_idx;
        av_d  = valid[man_idx];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= '0;
      any_valid_o <= 1'b0;
      switch_o    <= 1'b0;
    end else begin
      sel_q       <= sel_d;
      any_valid_o <= av_d;
      switch_o    <= (sel_d != sel_q);
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/ref_sel_chk.sv
module ref_sel_chk #(
  parameter int N_IN   = 2,
  parameter int PRIO_W = 3,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             mode_i,
  input logic                   sel_by_reg_i,
  input logic [SEL_W-1:0]       sel_pin_i,
  input logic [SEL_W-1:0]       sel_reg_i,
  input logic [N_IN*PRIO_W-1:0] prio_i,
  input logic [N_IN-1:0]        los_i,
  input logic [N_IN-1:0]        los_mask_i,
  input logic [N_IN-1:0]        oof_i,
  input logic [N_IN-1:0]        oof_mask_i,
  input logic [SEL_W-1:0]       sel_o,
  input logic                   any_valid_o,
  input logic                   switch_o
);
  logic [N_IN-1:0]  ok_in;
  logic [SEL_W-1:0] want;
  logic             is_auto;

  always_comb begin
    for (int k = 0; k < N_IN; k++)
      ok_in[k] = !(los_i[k] && !los_mask_i[k]) && !(oof_i[k] && !oof_mask_i[k])
                 && (prio_i[k*PRIO_W +: PRIO_W] != 0);
  end
  assign want    = sel_by_reg_i ? sel_reg_i : sel_pin_i;
  assign is_auto = (mode_i == 2'b01) || (mode_i == 2'b10);

  // R10
  pulse_means_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> (sel_o != $past(sel_o)));

  // R10
  change_means_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != $past(sel_o)) |-> switch_o);

  // R2
  manual_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_auto) |=> (sel_o == $past(want)));

  // R8
  nonrev_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && ok_in[sel_o]) |=> $stable(sel_o));

  // R9
  none_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_auto && ok_in == '0) |=> (!any_valid_o && $stable(sel_o)));
endmodule

bind ref_sel_top ref_sel_chk #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .sel_by_reg_i (sel_by_reg_i),
  .sel_pin_i    (sel_pin_i),
  .sel_reg_i    (sel_reg_i),
  .prio_i       (prio_i),
  .los_i        (los_i),
  .los_mask_i   (los_mask_i),
  .oof_i        (oof_i),
  .oof_mask_i   (oof_mask_i),
  .sel_o        (sel_o),
  .any_valid_o  (any_valid_o),
  .switch_o     (switch_o)
);

// File: tb/ref_sel_top_test.sv
module ref_sel_top_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       by_reg = 1'b0, pin = 1'b0, rreg = 1'b0;
  logic [5:0] prio = 6'b010_001;
  logic [1:0] los = '0, los_m = '0, oof = '0, oof_m = '0;
  logic       sel, av, sw;
  logic       m_sel;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_P/2) clk = ~clk;

  ref_sel_top uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sel_by_reg_i(by_reg),
    .sel_pin_i(pin), .sel_reg_i(rreg), .prio_i(prio), .los_i(los),
    .los_mask_i(los_m), .oof_i(oof), .oof_mask_i(oof_m),
    .sel_o(sel), .any_valid_o(av), .switch_o(sw)
  );

  function automatic bit vld(int k);
    return !((los[k] && !los_m[k]) || (oof[k] && !oof_m[k]));
  endfunction
  function automatic bit elg(int k);
    return vld(k) && (prio[k*3 +: 3] != 0);
  endfunction
  function automatic int best();
    int b = -1;
    for (int k = 0; k < 2; k++)
      if (elg(k) && (b < 0 || prio[k*3 +: 3] < prio[b*3 +: 3])) b = k;
    return b;
  endfunction
  function automatic bit exp_sel();
    int b = best();
    case (mode)
      2'b10:   return (b >= 0) ? b[0] : m_sel;
      2'b01:   return (!elg(int'(m_sel)) && b >= 0) ? b[0] : m_sel;
      default: return by_reg ? rreg : pin;
    endcase
  endfunction
  function automatic bit exp_av();
    if (mode == 2'b01 || mode == 2'b10) return best() >= 0;
    return vld(by_reg ? int'(rreg) : int'(pin));
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // called at a negedge with inputs set; returns at the next negedge
  task automatic step(string tag);
    bit es = exp_sel();
    bit ea = exp_av();
    bit ew = (es != m_sel);
    @(posedge clk); #1;
    chk(tag, sel, es, "sel_o");
    chk(tag, av, ea, "any_valid_o");
    chk("R10", sw, ew, "switch_o");
    m_sel = es;
    @(negedge clk);
  endtask

  task automatic clear();
    los = '0; oof = '0; los_m = '0; oof_m = '0; prio = 6'b010_001;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    m_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", sel, 0, "sel_o"); chk("R1", av, 0, "any_valid_o"); chk("R1", sw, 0, "switch_o");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 manual pin then register source
    mode = 2'b00; by_reg = 0; pin = 1; rreg = 0; step("R2");
    by_reg = 1; step("R2");
    rreg = 1; pin = 0; step("R2");
    // R3 reserved code acts as manual
    mode = 2'b11; by_reg = 0; step("R3");
    pin = 1; step("R3");
    // R9 manual any_valid follows chosen input
    los[1] = 1; step("R9");
    // R5 mask hides alarm
    los_m[1] = 1; step("R5");
    oof[1] = 1; step("R5");
    oof_m[1] = 1; step("R5");
    clear();

    // R7 revertive: fail primary, recover, return
    mode = 2'b10; step("R7");
    los[0] = 1; step("R7");
    chk("R7", sel, 1, "sel_o after primary loss");
    los[0] = 0; step("R7");
    chk("R7", sel, 0, "sel_o after primary recovery");
    // R4 pin/reg ignored in auto
    by_reg = 0; pin = 1; step("R4");
    by_reg = 1; rreg = 1; step("R4");

    // R8 non-revertive: stays on backup after primary returns
    mode = 2'b01; los[0] = 1; step("R8");
    los[0] = 0; step("R8");
    step("R8");
    chk("R8", sel, 1, "sel_o held on backup");
    // R6 priority 0 never chosen; tie goes to input 0
    mode = 2'b10; prio = 6'b001_000; step("R6");
    chk("R6", sel, 1, "sel_o with input0 prio 0");
    prio = 6'b000_001; step("R6");
    prio = 6'b011_011; step("R6");
    chk("R6", sel, 0, "sel_o on tie");
    prio = 6'b001_010; step("R6");
    // R9 no eligible input: hold and flag low
    oof = 2'b11; step("R9");
    mode = 2'b01; step("R9");
    clear();

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 8;
      mode   = (r < 3) ? 2'b10 : (r < 6) ? 2'b01 : $urandom;
      by_reg = $urandom; pin = $urandom; rreg = $urandom;
      if ($urandom % 16 == 0) prio = $urandom % 64;
      for (int k = 0; k < 2; k++) begin
        if ($urandom % 6 == 0) los[k] = ~los[k];
        if ($urandom % 8 == 0) oof[k] = ~oof[k];
        if ($urandom % 12 == 0) los_m[k] = ~los_m[k];
        if ($urandom % 12 == 0) oof_m[k] = ~oof_m[k];
      end
      case (mode)
        2'b10:   step("R7");
        2'b01:   step("R8");
        2'b11:   step("R3");
        default: step("R2");
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule